// File: doc/BRIEF.md
# Accelerator Command Queue Front End

This block sits between a 16-bit register bus and a drawing engine that consumes 32-bit commands. Software builds each command in two writes: first the upper half into a holding register, then the lower half, whose write joins both halves and places the complete word at the tail of an on-chip queue. The drawing engine drains the queue through a valid/ready stream, oldest command first.

Software learns how much room is left by reading a pending-command count. It writes a burst of N commands only once that count is at most the depth minus N. A clear write discards everything queued. A sticky flag records that a push arrived while the queue was full and was thrown away. A constant output gives the configured size in the depth-minus-one form that setup code programs.

Top module: `cmd_queue_front`

## Requirements
- R1: After reset, `pending_count` is 0, `cmd_valid` is 0 and `overflow` is 0.
- R2: A write with `wr_sel` = 0 loads `wr_data` into the upper-half holding register and queues nothing. A write with `wr_sel` = 3 has no effect. Neither changes `pending_count`.
- R3: A write with `wr_sel` = 1 queues the word {holding register, `wr_data`}, with the holding register in bits 31:16. `pending_count` is one higher on the cycle after the write.
- R4: Commands leave on `cmd_data` in the order they were queued. While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_data` holds steady.
- R5: `pending_count` falls by one only on a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_valid` is 1 exactly when `pending_count` is nonzero.
- R6: The queue holds DEPTH (default 512) commands. A low-half write while `pending_count` equals DEPTH is discarded and sets `overflow`. `overflow` stays set until a clear.
- R7: A write with `wr_sel` = 2 and `wr_data[0]` = 1 empties the queue and drops `overflow` by the next cycle. With `wr_data[0]` = 0 the write does nothing.
- R8: A clear in the same cycle as an accepted stream transfer wins. `pending_count` is 0 on the next cycle, not DEPTH-style wrapped or off by one.
- R9: `size_m1` always equals DEPTH-1 (511 by default).
- R10: The holding register keeps its value across low-half writes, so several low-half writes after one upper-half write share the same upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 upper half, 1 lower half and push, 2 clear, 3 unused |
| wr_data | input | 16 | Write data |
| cmd_valid | output | 1 | Queue head available |
| cmd_ready | input | 1 | Engine accepts the head this cycle |
| cmd_data | output | 32 | Queue head command |
| pending_count | output | 10 | Number of queued commands |
| overflow | output | 1 | Sticky: a push was dropped while the queue was full |
| size_m1 | output | 10 | Queue depth minus one |

## Verification
The bench fills the queue to exactly its depth and then adds one more command. A design with an off-by-one full test would either store the extra word, so it shows up when the queue is drained, or refuse the last legal one, so the count reads 511. It clears the queue in the same cycle the engine takes the head; a design that let the pop also act would leave the count wrapped or unequal to zero. It writes several lower halves after one upper half. A design that reset the holding register on push would emit zeros in bits 31:16. It also stalls the stream while new words are pushed, which catches a head that follows the write pointer.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned CMD_W  = 2 * HALF_W;

    typedef enum logic [1:0] {
        SEL_UPPER = 2'd0,
        SEL_LOWER = 2'd1,
        SEL_FLUSH = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] upper;
        logic [HALF_W-1:0] lower;
    } cmd_word_t;

    function automatic cmd_word_t join_halves(input logic [HALF_W-1:0] up,
                                              input logic [HALF_W-1:0] lo);
        cmd_word_t w;
        w.upper = up;
        w.lower = lo;
        return w;
    endfunction

endpackage

// File: rtl/cmdq_assembler.sv
module cmdq_assembler
    import cmdq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic              push,
    output cmd_word_t         push_word,
    output logic              flush
);

    logic [HALF_W-1:0] upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
        end else if (wr_en && wr_sel == SEL_UPPER) begin
            upper_q <= wr_data;
        end
    end

    always_comb begin
        push      = wr_en && (wr_sel == SEL_LOWER);
        push_word = join_halves(upper_q, wr_data);
        flush     = wr_en && (wr_sel == SEL_FLUSH) && wr_data[0];
    end

    AST_UPPER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_LOWER) |=> $stable(upper_q)) else $error("upper half lost"); // R10

endmodule

// File: rtl/cmdq_store.sv
module cmdq_store
    import cmdq_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  cmd_word_t     push_word,
    input  logic          flush,
    input  logic          pop_ready,
    output logic          head_valid,
    output cmd_word_t     head_word,
    output logic [CW-1:0] count,
    output logic          overflow
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    cmd_word_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full       = (count == FULL_CNT);
        head_valid = (count != '0);
        head_word  = mem[rd_ptr];
        do_push    = push && !full && !flush;
        do_pop     = head_valid && pop_ready && !flush;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            overflow <= 1'b0;
        end else if (push && full) begin
            overflow <= 1'b1;
        end
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT) else $error("count above depth"); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush && !pop_ready) |=> (count == FULL_CNT && overflow)) else $error("full push not dropped"); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !flush) |=> overflow) else $error("overflow lost"); // R6
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !overflow)) else $error("flush left entries"); // R7 R8
    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !pop_ready && !flush) |=> $stable(head_word)) else $error("head moved while stalled"); // R4
    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (head_valid && pop_ready && !push && !flush) |=> (count == $past(count) - CW'(1))) else $error("pop did not decrement"); // R5

endmodule

// File: rtl/cmd_queue_front.sv
module cmd_queue_front
    import cmdq_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CMD_W-1:0]  cmd_data,
    output logic [CW-1:0]     pending_count,
    output logic              overflow,
    output logic [CW-1:0]     size_m1
);

    localparam int unsigned AW = $clog2(DEPTH);

    reg_sel_e  sel;
    logic      push;
    logic      flush;
    cmd_word_t push_word;
    cmd_word_t head_word;

    assign sel      = reg_sel_e'(wr_sel);
    assign cmd_data = head_word;
    assign size_m1  = CW'(DEPTH - 1);

    cmdq_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (sel),
        .wr_data   (wr_data),
        .push      (push),
        .push_word (push_word),
        .flush     (flush)
    );

    cmdq_store #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .CW    (CW)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_word  (push_word),
        .flush      (flush),
        .pop_ready  (cmd_ready),
        .head_valid (cmd_valid),
        .head_word  (head_word),
        .count      (pending_count),
        .overflow   (overflow)
    );

    AST_VALID_TRACKS_COUNT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid == (pending_count != '0)) else $error("valid disagrees with count"); // R5
    AST_NON_PUSH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 2'd0 || wr_sel == 2'd3) && !(cmd_valid && cmd_ready))
        |=> $stable(pending_count)) else $error("non-push write moved count"); // R2
    AST_PUSH_INC: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && pending_count != CW'(DEPTH) && !cmd_ready)
        |=> (pending_count == $past(pending_count) + CW'(1))) else $error("push did not count"); // R3

endmodule

// File: tb/tb_cmd_queue_front.sv
module tb_cmd_queue_front;

    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_data;
    logic [9:0]  pending_count;
    logic        overflow;
    logic [9:0]  size_m1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    cmd_queue_front #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .pending_count(pending_count), .overflow(overflow), .size_m1(size_m1)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_cmd(input logic [31:0] w, input bit keep);
        wr(2'd0, w[31:16]);
        wr(2'd1, w[15:0]);
        if (keep) exp_q.push_back(w);
    endtask

    task automatic pop_one(input string tag);
        logic [9:0] prev;
        prev = pending_count;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        check(pending_count == prev - 10'd1, tag, 32'(pending_count), 32'(prev - 10'd1));
    endtask

    // Scoreboard monitor: compares each accepted head with the expected queue (R4)
    initial begin
        logic [31:0] w;
        forever begin
            @(negedge clk);
            #1;
            if (!rst && cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected output", cmd_data, 32'h0);
                end else begin
                    w = exp_q.pop_front();
                    check(cmd_data == w, "R4 order", cmd_data, w);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R9 size
        check(pending_count == 0, "R1 count", 32'(pending_count), 0);
        check(cmd_valid == 0, "R1 valid", 32'(cmd_valid), 0);
        check(overflow == 0, "R1 overflow", 32'(overflow), 0);
        check(size_m1 == 10'd511, "R9 size_m1", 32'(size_m1), 511);

        // R2 upper-half and spare writes queue nothing
        wr(2'd0, 16'hBEEF);
        check(pending_count == 0, "R2 upper write", 32'(pending_count), 0);
        wr(2'd3, 16'h1111);
        check(pending_count == 0, "R2 spare write", 32'(pending_count), 0);

        // R3 pushes, R10 shared upper half
        push_cmd(32'hCAFE_0001, 1'b1);
        check(pending_count == 1, "R3 count after push", 32'(pending_count), 1);
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'h0001); exp_q.push_back(32'h1234_0001);
        wr(2'd1, 16'h0002); exp_q.push_back(32'h1234_0002);
        check(pending_count == 3, "R10 count", 32'(pending_count), 3);

        // R4 head steady while stalled
        check(cmd_data == 32'hCAFE_0001, "R4 head", cmd_data, 32'hCAFE_0001);
        @(negedge clk);
        check(cmd_data == 32'hCAFE_0001, "R4 stalled head", cmd_data, 32'hCAFE_0001);

        // R5 count drops one per accept; monitor verifies R10 words
        pop_one("R5 pop 1");
        pop_one("R5 pop 2");
        pop_one("R5 pop 3");
        check(cmd_valid == 0, "R5 empty valid", 32'(cmd_valid), 0);

        // R7 clear with bit0 low does nothing, high empties
        push_cmd(32'h0BAD_0001, 1'b1);
        push_cmd(32'h0BAD_0002, 1'b1);
        wr(2'd2, 16'h0000);
        check(pending_count == 2, "R7 no-op clear", 32'(pending_count), 2);
        wr(2'd2, 16'h0001);
        exp_q.delete();
        check(pending_count == 0, "R7 clear", 32'(pending_count), 0);

        // R6 fill to depth then one extra
        for (int i = 0; i < DEPTH; i++) push_cmd(32'hA000_0000 + i, 1'b1);
        check(pending_count == 10'(DEPTH), "R6 full count", 32'(pending_count), DEPTH);
        check(overflow == 0, "R6 no overflow yet", 32'(overflow), 0);
        push_cmd(32'hDEAD_BEEF, 1'b0);
        check(pending_count == 10'(DEPTH), "R6 drop count", 32'(pending_count), DEPTH);
        check(overflow == 1, "R6 overflow set", 32'(overflow), 1);
        pop_one("R5 pop from full");
        pop_one("R5 pop from full 2");
        check(overflow == 1, "R6 overflow sticky", 32'(overflow), 1);
        cmd_ready = 1'b1;
        repeat (DEPTH - 2) @(negedge clk);
        cmd_ready = 1'b0;
        check(pending_count == 0, "R6 drained", 32'(pending_count), 0);
        check(exp_q.size() == 0, "R6 all delivered", 32'(exp_q.size()), 0);
        wr(2'd2, 16'h0001);
        check(overflow == 0, "R7 clear overflow", 32'(overflow), 0);

        // R8 clear beats a concurrent pop
        push_cmd(32'h5555_0001, 1'b1);
        push_cmd(32'h5555_0002, 1'b1);
        cmd_ready = 1'b1;
        wr(2'd2, 16'h0001);
        cmd_ready = 1'b0;
        exp_q.delete();
        check(pending_count == 0, "R8 count", 32'(pending_count), 0);
        check(cmd_valid == 0, "R8 valid", 32'(cmd_valid), 0);

        // queue usable after clear
        push_cmd(32'h7777_8888, 1'b1);
        check(cmd_data == 32'h7777_8888, "R3 after clear", cmd_data, 32'h7777_8888);
        pop_one("R5 final pop");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule